// File: doc/BRIEF.md
# PLL Clock-Chip Bring-Up Sequencer

This block configures an external clock-distribution PLL over SPI straight out of reset. No processor is involved. It builds 16-bit register frames and passes them one at a time to an existing SPI master through a start/busy handshake. The sequence is fixed: soft-reset the chip, wait for it to settle, read and check its identity, drive the operating-mode pins, then write the whole configuration table. After that it either waits for PLL lock or waits a fixed time. Last, it moves the system clock onto the PLL output.

The 2-bit mode input is captured once, just before configuration starts. Bit 0 of the captured mode selects the table variant and the lock policy. Modes 1 and 3 use a reference input: the PLL, VCO and lock detector are powered, and the sequencer polls the lock flag within a cycle budget. Modes 0 and 2 forward the input clock and only wait a fixed delay. A wrong identity value or an expired lock budget ends the sequence with `error_o` high, and the clock select is never raised.

Top module: `pllinit_seq`

FSM states, with the transitions each one takes:

- RST_TX → RST_WT → SETTLE, on frame acknowledge.
- SETTLE → ID_TX, when the delay ends.
- ID_TX → ID_WT.
- ID_WT → PINS if the identity matches, otherwise FAIL.
- PINS → CFG_TX → CFG_WT.
- CFG_WT → CFG_TX, for each remaining table entry.
- CFG_WT → LOCK_TX after the last entry with reference mode, or → HOLD after the last entry in the other modes.
- LOCK_TX → LOCK_WT.
- LOCK_WT → SWITCH if the lock bit is set, → FAIL if the budget is spent, otherwise → LOCK_TX.
- HOLD → SWITCH, when the delay ends.
- SWITCH → FINAL.
- FINAL → DONE, when the delay ends.
- DONE and FAIL are terminal until reset.

## Requirements
- R1: Frame layout is register address in bits 15:9, read flag in bit 8 (1 = read) and data in bits 7:0. `spi_start_o` is a one-cycle pulse with `spi_frame_o` held until the frame completes. A new start is issued only after `spi_busy_i` has been low again.
- R2: The first frame is the write 0x0604 (value 0x04 to register 0x03). At least RST_SETTLE cycles pass between the end of that frame and the start of the next.
- R3: The second frame is the read 0x2D00 (register 0x16). If the returned byte is not 0x65, `error_o` rises, no further frame is issued, and `clk_sel_o` and `done_o` stay 0.
- R4: `mode_pin_o` takes the value of `mode_i` before the first configuration frame. It then holds that value; later changes on `mode_i` have no effect on the pins or the sequence.
- R5: Configuration writes registers 0x01 to 0x15 in ascending order, one frame each. With mode bit 0 set, registers 1, 2 and 3 get 0x04, 0x3B and 0x08. With mode bit 0 clear, they get 0x00, 0x00 and 0x70. Registers 0x04 to 0x15 get F0 98 00 00 02 00 19 41 80 81 80 81 80 81 00 01 00 01.
- R6: With mode bit 0 set, the sequencer repeats the read frame 0x0100 (register 0x00) until bit 2 of the returned byte is 1. Other bits are ignored.
- R7: With mode bit 0 clear, no frame follows the last configuration frame. The sequencer waits SLAVE_WAIT cycles instead.
- R8: If a lock poll returns without bit 2 and LOCK_TIMEOUT cycles have elapsed since polling began, `error_o` rises and the clock switch is skipped. A poll that returns with bit 2 set succeeds even when the budget has already expired.
- R9: `clk_sel_o` rises after configuration and lock handling and stays high. `done_o` rises exactly SWITCH_WAIT+2 cycles later. `done_o` and `error_o` are never high together, and both hold until reset.
- R10: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset; the sequence starts on release |
| mode_i | input | 2 | Operating mode, captured once before configuration |
| spi_start_o | output | 1 | One-cycle request to the SPI master to send the frame |
| spi_frame_o | output | 16 | Frame to shift out, MSB first |
| spi_busy_i | input | 1 | SPI master busy; a falling edge ends the frame |
| spi_rdata_i | input | 8 | Byte received in the last frame |
| mode_pin_o | output | 2 | Mode bits driven toward the PLL board |
| clk_sel_o | output | 1 | Moves the system clock to the PLL output |
| done_o | output | 1 | Bring-up completed |
| error_o | output | 1 | Bring-up aborted (bad identity or lock timeout) |

## Verification
Two events can land in the same cycle: the lock budget running out, and a poll frame completing. The bench forces this by stretching the busy time of every lock poll beyond LOCK_TIMEOUT, so the first poll always returns after the budget has expired. When that late poll reports lock, the run must end with `done_o` and without `error_o`, after exactly one poll. When the late poll reports no lock, the run must end with `error_o` after exactly one poll, and `clk_sel_o` must never rise.

// File: rtl/pllinit_pkg.sv
package pllinit_pkg;

    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int FRAME_W   = ADDR_W + 1 + DATA_W;
    localparam int CFG_FIRST = 1;
    localparam int CFG_LAST  = 21;
    localparam int CFG_COUNT = CFG_LAST - CFG_FIRST + 1;
    localparam int IDX_W     = $clog2(CFG_COUNT);
    localparam int LOCK_BIT  = 2;

    typedef logic [ADDR_W-1:0]  reg_addr_t;
    typedef logic [DATA_W-1:0]  reg_data_t;
    typedef logic [FRAME_W-1:0] frame_t;

    localparam reg_addr_t SRST_REG  = 7'h03;
    localparam reg_data_t SRST_VAL  = 8'h04;
    localparam reg_addr_t IDENT_REG = 7'h16;
    localparam reg_data_t IDENT_VAL = 8'h65;
    localparam reg_addr_t STAT_REG  = 7'h00;

    typedef enum logic [3:0] {
        S_RST_TX, S_RST_WT, S_SETTLE, S_ID_TX, S_ID_WT, S_PINS,
        S_CFG_TX, S_CFG_WT, S_LOCK_TX, S_LOCK_WT, S_HOLD,
        S_SWITCH, S_FINAL, S_DONE, S_FAIL
    } seq_state_t;

    typedef enum logic [1:0] {L_IDLE, L_LAUNCH, L_ARMED, L_WAIT} link_state_t;

    function automatic frame_t mk_frame(input reg_addr_t a, input logic rd, input reg_data_t d);
        return {a, rd, d};
    endfunction

endpackage

// File: rtl/pllinit_timer.sv
module pllinit_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load_i)       cnt_q <= val_i;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R9: with no reload, a running count never grows
    a_r9_timer_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/pllinit_cfg_rom.sv
module pllinit_cfg_rom
    import pllinit_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    input  logic             ref_en_i,
    output reg_addr_t        addr_o,
    output reg_data_t        data_o
);

    assign addr_o = reg_addr_t'(CFG_FIRST) + reg_addr_t'(idx_i);

    always_comb begin
        case (addr_o)
            7'h01: data_o = ref_en_i ? 8'h04 : 8'h00;
            7'h02: data_o = ref_en_i ? 8'h3B : 8'h00;
            7'h03: data_o = ref_en_i ? 8'h08 : 8'h70;
            7'h04: data_o = 8'hF0;
            7'h05: data_o = 8'h98;
            7'h08: data_o = 8'h02;
            7'h0A: data_o = 8'h19;
            7'h0B: data_o = 8'h41;
            7'h0C, 7'h0E, 7'h10: data_o = 8'h80;
            7'h0D, 7'h0F, 7'h11: data_o = 8'h81;
            7'h13, 7'h15: data_o = 8'h01;
            default: data_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/pllinit_spi_link.sv
module pllinit_spi_link
    import pllinit_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_i,
    input  frame_t    frame_i,
    output logic      ack_o,
    output reg_data_t rdata_o,
    output logic      spi_start_o,
    output frame_t    spi_frame_o,
    input  logic      spi_busy_i,
    input  reg_data_t spi_rdata_i
);

    link_state_t st_q;
    frame_t      frame_q;
    logic        ack_q;
    reg_data_t   rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= L_IDLE;
            frame_q <= '0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= 1'b0;
            unique case (st_q)
                L_IDLE: if (req_i) begin
                    frame_q <= frame_i;
                    st_q    <= L_LAUNCH;
                end
                L_LAUNCH: st_q <= L_ARMED;
                L_ARMED:  st_q <= L_WAIT;
                L_WAIT: if (!spi_busy_i) begin
                    st_q    <= L_IDLE;
                    ack_q   <= 1'b1;
                    rdata_q <= spi_rdata_i;
                end
                default: st_q <= L_IDLE;
            endcase
        end
    end

    assign spi_start_o = (st_q == L_LAUNCH);
    assign spi_frame_o = frame_q;
    assign ack_o       = ack_q;
    assign rdata_o     = rdata_q;

    // R1: start is a single-cycle pulse
    a_r1_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        spi_start_o |=> !spi_start_o);
    // R1: frame held steady while the master works on it
    a_r1_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == L_ARMED || st_q == L_WAIT) |-> $stable(spi_frame_o));
    // R1: a new request only arrives once the previous frame is finished
    a_r1_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |-> (st_q == L_IDLE));

endmodule

// File: rtl/pllinit_seq.sv
module pllinit_seq
    import pllinit_pkg::*;
#(
    parameter int RST_SETTLE   = 64,
    parameter int SLAVE_WAIT   = 256,
    parameter int SWITCH_WAIT  = 1024,
    parameter int LOCK_TIMEOUT = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode_i,
    output logic        spi_start_o,
    output logic [15:0] spi_frame_o,
    input  logic        spi_busy_i,
    input  logic [7:0]  spi_rdata_i,
    output logic [1:0]  mode_pin_o,
    output logic        clk_sel_o,
    output logic        done_o,
    output logic        error_o
);

    localparam int DMAX_A = (RST_SETTLE > SLAVE_WAIT) ? RST_SETTLE : SLAVE_WAIT;
    localparam int DMAX   = (DMAX_A > SWITCH_WAIT) ? DMAX_A : SWITCH_WAIT;
    localparam int DLY_W  = $clog2(DMAX + 1);
    localparam int LCK_W  = $clog2(LOCK_TIMEOUT + 1);

    seq_state_t       st_q, st_nx;
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       mode_q;
    logic             clk_sel_q, done_q, err_q;

    logic       req;
    frame_t     req_frame;
    logic       ack;
    reg_data_t  rdata;
    reg_addr_t  rom_addr;
    reg_data_t  rom_data;
    logic       ref_en;
    logic       cfg_last;
    logic       dly_load, dly_zero, lck_load, lck_zero;
    logic [DLY_W-1:0] dly_val;

    assign ref_en   = mode_q[0];
    assign cfg_last = (idx_q == IDX_W'(CFG_COUNT - 1));

    pllinit_cfg_rom u_rom (
        .idx_i    (idx_q),
        .ref_en_i (ref_en),
        .addr_o   (rom_addr),
        .data_o   (rom_data)
    );

    pllinit_spi_link u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .frame_i     (req_frame),
        .ack_o       (ack),
        .rdata_o     (rdata),
        .spi_start_o (spi_start_o),
        .spi_frame_o (spi_frame_o),
        .spi_busy_i  (spi_busy_i),
        .spi_rdata_i (spi_rdata_i)
    );

    pllinit_timer #(.W(DLY_W)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (dly_load),
        .val_i  (dly_val),
        .zero_o (dly_zero)
    );

    pllinit_timer #(.W(LCK_W)) u_lck (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (lck_load),
        .val_i  (LCK_W'(LOCK_TIMEOUT)),
        .zero_o (lck_zero)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_RST_TX;
        else        st_q <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_RST_TX:  st_nx = S_RST_WT;
            S_RST_WT:  if (ack) st_nx = S_SETTLE;
            S_SETTLE:  if (dly_zero) st_nx = S_ID_TX;
            S_ID_TX:   st_nx = S_ID_WT;
            S_ID_WT:   if (ack) st_nx = (rdata == IDENT_VAL) ? S_PINS : S_FAIL;
            S_PINS:    st_nx = S_CFG_TX;
            S_CFG_TX:  st_nx = S_CFG_WT;
            S_CFG_WT:  if (ack) begin
                if (!cfg_last)   st_nx = S_CFG_TX;
                else if (ref_en) st_nx = S_LOCK_TX;
                else             st_nx = S_HOLD;
            end
            S_LOCK_TX: st_nx = S_LOCK_WT;
            S_LOCK_WT: if (ack) begin
                if (rdata[LOCK_BIT]) st_nx = S_SWITCH;
                else if (lck_zero)   st_nx = S_FAIL;
                else                 st_nx = S_LOCK_TX;
            end
            S_HOLD:    if (dly_zero) st_nx = S_SWITCH;
            S_SWITCH:  st_nx = S_FINAL;
            S_FINAL:   if (dly_zero) st_nx = S_DONE;
            S_DONE:    st_nx = S_DONE;
            S_FAIL:    st_nx = S_FAIL;
            default:   st_nx = S_FAIL;
        endcase
    end

    // frame request and timer control
    always_comb begin
        req       = 1'b0;
        req_frame = '0;
        dly_load  = 1'b0;
        dly_val   = '0;
        lck_load  = 1'b0;
        unique case (st_q)
            S_RST_TX:  begin req = 1'b1; req_frame = mk_frame(SRST_REG, 1'b0, SRST_VAL); end
            S_ID_TX:   begin req = 1'b1; req_frame = mk_frame(IDENT_REG, 1'b1, '0); end
            S_CFG_TX:  begin req = 1'b1; req_frame = mk_frame(rom_addr, 1'b0, rom_data); end
            S_LOCK_TX: begin req = 1'b1; req_frame = mk_frame(STAT_REG, 1'b1, '0); end
            S_RST_WT:  if (ack) begin dly_load = 1'b1; dly_val = DLY_W'(RST_SETTLE); end
            S_CFG_WT:  if (ack && cfg_last) begin
                if (ref_en) lck_load = 1'b1;
                else begin dly_load = 1'b1; dly_val = DLY_W'(SLAVE_WAIT); end
            end
            S_SWITCH:  begin dly_load = 1'b1; dly_val = DLY_W'(SWITCH_WAIT); end
            default: ;
        endcase
    end

    // table index and mode capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mode_q <= '0;
        end else begin
            if (st_q == S_PINS) begin
                idx_q  <= '0;
                mode_q <= mode_i;
            end else if (st_q == S_CFG_WT && ack && !cfg_last) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel_q <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            clk_sel_q <= (st_nx == S_SWITCH) || (st_nx == S_FINAL) || (st_nx == S_DONE);
            done_q    <= (st_nx == S_DONE);
            err_q     <= (st_nx == S_FAIL);
        end
    end

    assign mode_pin_o = mode_q;
    assign clk_sel_o  = clk_sel_q;
    assign done_o     = done_q;
    assign error_o    = err_q;

    // R3 / R8: an aborted bring-up never moves the clock
    a_r3_err_no_switch: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> !clk_sel_o);
    // R3: nothing goes out on the SPI bus after an abort
    a_r3_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> !spi_start_o);
    // R9: clock select is sticky
    a_r9_clksel_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        clk_sel_o |=> clk_sel_o);
    // R9: done and error are exclusive
    a_r9_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));
    // R4: mode pins hold during configuration
    a_r4_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_CFG_WT) |=> $stable(mode_pin_o));
    // R6 / R7: lock polling only in reference modes
    a_r6_poll_ref_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_LOCK_TX) |-> mode_pin_o[0]);

endmodule

// File: tb/pllinit_seq_tb_top.sv
module pllinit_seq_tb_top;

    localparam int T_SETTLE = 16;
    localparam int T_SLAVE  = 30;
    localparam int T_SWITCH = 40;
    localparam int T_LOCK   = 60;
    localparam int NORM_LEN = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        spi_start_o;
    logic [15:0] spi_frame_o;
    logic        spi_busy = 1'b0;
    logic [7:0]  spi_rdata = 8'h00;
    logic [1:0]  mode_pin_o;
    logic        clk_sel_o, done_o, error_o;

    always #2 clk = ~clk;

    pllinit_seq #(
        .RST_SETTLE   (T_SETTLE),
        .SLAVE_WAIT   (T_SLAVE),
        .SWITCH_WAIT  (T_SWITCH),
        .LOCK_TIMEOUT (T_LOCK)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .spi_start_o (spi_start_o),
        .spi_frame_o (spi_frame_o),
        .spi_busy_i  (spi_busy),
        .spi_rdata_i (spi_rdata),
        .mode_pin_o  (mode_pin_o),
        .clk_sel_o   (clk_sel_o),
        .done_o      (done_o),
        .error_o     (error_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];

    // case controls
    logic [1:0] cur_mode;
    logic [7:0] id_reply;
    int  lock_after, poll_len, polls;
    bit  poll_ok, flip;
    // monitor state
    int  cyc = 0, bcnt = 0, fidx = 0;
    int  t_rst_end = 0, t_clk = -1, t_done = -1;
    bit  clk_prev = 0, done_prev = 0;
    logic [7:0] reply = 8'h00;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] cfg_val(input int a, input bit rf);
        case (a)
            1:  return rf ? 8'h04 : 8'h00;
            2:  return rf ? 8'h3B : 8'h00;
            3:  return rf ? 8'h08 : 8'h70;
            4:  return 8'hF0;
            5:  return 8'h98;
            8:  return 8'h02;
            10: return 8'h19;
            11: return 8'h41;
            12, 14, 16: return 8'h80;
            13, 15, 17: return 8'h81;
            19, 21: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // SPI master model and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            spi_busy = 1'b0; bcnt = 0; clk_prev = 0; done_prev = 0;
        end else begin
            if (clk_sel_o && !clk_prev) t_clk = cyc;
            if (done_o && !done_prev)   t_done = cyc;
            clk_prev = clk_sel_o; done_prev = done_o;
            if (spi_busy) begin
                if (bcnt <= 1) begin
                    spi_busy = 1'b0; spi_rdata = reply;
                    if (fidx == 1) t_rst_end = cyc;
                end else bcnt--;
            end
            if (spi_start_o) begin
                logic [6:0] a;
                logic rd;
                a  = spi_frame_o[15:9];
                rd = spi_frame_o[8];
                chk(!spi_busy, "R1", "start while busy", 1, 0);
                if (fidx == 1)
                    chk((cyc - t_rst_end) >= T_SETTLE, "R2", "settle gap", cyc - t_rst_end, T_SETTLE);
                if (fidx == 2) begin
                    chk(mode_pin_o == cur_mode, "R4", "mode pins at first config", mode_pin_o, cur_mode);
                    if (flip) mode_i = ~cur_mode;
                end
                if (exp_q.size() > 0) begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(spi_frame_o == e, (fidx == 0) ? "R2" : (fidx == 1) ? "R3" : "R5",
                        "frame", spi_frame_o, e);
                end else if (poll_ok && spi_frame_o == 16'h0100) begin
                    n_vec++;
                end else begin
                    chk(1'b0, poll_ok ? "R6" : "R7", "unexpected frame", spi_frame_o, 0);
                end
                if (rd && a == 7'h00) begin
                    reply = (polls >= lock_after) ? 8'h04 : 8'hFB;
                    polls++;
                    bcnt  = poll_len;
                end else begin
                    reply = (rd && a == 7'h16) ? id_reply : 8'h00;
                    bcnt  = NORM_LEN;
                end
                spi_busy = 1'b1;
                fidx++;
            end
        end
    end

    // driver: one bring-up run with its expected frame stream
    task automatic run_case(input logic [1:0] m, input logic [7:0] idv, input int la,
                            input int plen, input bit fl, input bit exp_ok, input int exp_polls);
        rst_n = 1'b0;
        mode_i = m; cur_mode = m; id_reply = idv; lock_after = la; poll_len = plen;
        flip = fl; poll_ok = m[0]; polls = 0; fidx = 0; t_clk = -1; t_done = -1;
        exp_q.delete();
        exp_q.push_back(16'h0604);
        exp_q.push_back(16'h2D00);
        if (idv == 8'h65)
            for (int a = 1; a <= 21; a++)
                exp_q.push_back({a[6:0], 1'b0, cfg_val(a, m[0])});
        repeat (4) @(negedge clk);
        chk({spi_start_o, mode_pin_o, clk_sel_o, done_o, error_o} == 6'd0, "R10",
            "outputs in reset", {spi_start_o, mode_pin_o, clk_sel_o, done_o, error_o}, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done_o || error_o) break;
        end
        repeat (80) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "frames missing", exp_q.size(), 0);
        chk(done_o == exp_ok, "R9", "done", done_o, exp_ok);
        chk(error_o == !exp_ok, exp_ok ? "R9" : (idv != 8'h65 ? "R3" : "R8"), "error", error_o, !exp_ok);
        chk(clk_sel_o == exp_ok, exp_ok ? "R9" : "R3", "clk_sel", clk_sel_o, exp_ok);
        chk(mode_pin_o == ((idv == 8'h65) ? m : 2'd0), "R4", "mode pins held", mode_pin_o, m);
        if (exp_polls >= 0)
            chk(polls == exp_polls, m[0] ? "R6" : "R7", "poll count", polls, exp_polls);
        else
            chk(polls >= 2, "R8", "polls before timeout", polls, 2);
        if (exp_ok)
            chk((t_done - t_clk) == T_SWITCH + 2, "R9", "switch to done delay", t_done - t_clk, T_SWITCH + 2);
    endtask

    initial begin
        // lock on third poll, grandmaster-style mode
        run_case(2'd3, 8'h65, 2, NORM_LEN, 1'b0, 1'b1, 3);
        // forwarding mode, mode input changed mid-configuration is ignored (R4, R7)
        run_case(2'd2, 8'h65, 0, NORM_LEN, 1'b1, 1'b1, 0);
        // wrong identity aborts (R3)
        run_case(2'd1, 8'h64, 0, NORM_LEN, 1'b0, 1'b0, 0);
        // lock never comes: timeout after several polls (R8)
        run_case(2'd1, 8'h65, 1000, NORM_LEN, 1'b0, 1'b0, -1);
        // poll completes after budget expired but reports lock: success (R8)
        run_case(2'd3, 8'h65, 0, 80, 1'b0, 1'b1, 1);
        // same coincidence without lock: single poll then error (R8)
        run_case(2'd1, 8'h65, 1000, 80, 1'b0, 1'b0, 1);
        // mode 0 behaves as forwarding (R7)
        run_case(2'd0, 8'h65, 0, NORM_LEN, 1'b0, 1'b1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule